// File: doc/BRIEF.md
# DDR2 Refresh and Self-Refresh Scheduler

This block sits beside a DDR2 memory controller and decides when the device must be refreshed. A free-running interval counter marks a refresh as due once per average refresh interval. A case-temperature flag picks either the normal interval or the shorter interval for a hot part. Due refreshes pile up in a small pending counter, and a request is held towards the controller until it reports, with a one-cycle strobe, that a refresh was issued. That strobe opens a blocking window as long as the refresh cycle time. During the window the device must not see another refresh or an activate.

The block also tracks self-refresh. An enter strobe freezes refresh scheduling. An exit strobe restarts the interval from a full period and runs a recovery counter. That counter raises one ready flag when non-read commands are allowed and a second, later flag when reads are allowed. All times are given in nanoseconds and converted to clock cycles with rounding up, based on the clock period parameter.

Top module: `ddr_refresh_sched`

## Requirements
- R1: While reset is asserted, `ref_req_o`, `busy_o`, `overflow_o` and `pend_o` are 0, and both ready flags are 1.
- R2: With `hot_i` low, a refresh becomes due every N = ceil(REFI_NORM_NS/clock period) cycles. After reset is released, the first one makes `pend_o` go to 1 on clock edge N.
- R3: With `hot_i` high, the interval is ceil(REFI_HOT_NS/clock period). A change of `hot_i` takes effect only when the interval counter next reloads.
- R4: `ref_req_o` is high exactly when `pend_o` is non-zero, the block is not busy and self-refresh is not active. A `ref_done_i` pulse is accepted only while `ref_req_o` is high, and it lowers `pend_o` by one. At any other time it has no effect.
- R5: An accepted `ref_done_i` holds `busy_o` high for ceil(RFC_NS/clock period) cycles, starting at the clock edge that accepts it.
- R6: `pend_o` saturates at MAX_PEND. A refresh that falls due while `pend_o` is at MAX_PEND sets `overflow_o`, and `overflow_o` then stays set until reset.
- R7: An `sr_enter_i` pulse outside self-refresh starts self-refresh. While self-refresh is active, `ref_req_o` and both ready flags are low, the interval counter is frozen, and `pend_o` keeps its value.
- R8: An `sr_exit_i` pulse during self-refresh ends it. `rdy_nonread_o` rises ceil((RFC_NS+XSNR_EXTRA_NS)/clock period) cycles after the accepting edge. The next refresh falls due one full interval after that edge. `sr_exit_i` outside self-refresh has no effect.
- R9: `rdy_read_o` rises XSRD_CK cycles after the edge that accepts `sr_exit_i`. It is never high while `rdy_nonread_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hot_i | input | 1 | Case temperature above 85 C, selects the short interval |
| ref_done_i | input | 1 | One-cycle strobe: controller issued a refresh |
| sr_enter_i | input | 1 | One-cycle strobe: device entered self-refresh |
| sr_exit_i | input | 1 | One-cycle strobe: device left self-refresh |
| ref_req_o | output | 1 | Refresh request to the controller |
| busy_o | output | 1 | Refresh cycle time window running |
| rdy_nonread_o | output | 1 | Non-read commands allowed |
| rdy_read_o | output | 1 | Read commands allowed |
| pend_o | output | PEND_W (4) | Number of outstanding refreshes |
| overflow_o | output | 1 | Sticky: a due refresh was lost at saturation |

## Verification
Every result in this block is registered, so each one appears after the clock edge that samples the stimulus. `busy_o` and a lower `pend_o` appear one edge after an accepted strobe. A due refresh shows in `pend_o` exactly N edges after the previous reload. The two ready flags rise a computed 39 and 200 edges after the exit strobe. The bench counts edges since reset release and drives strobes on falling edges. It samples one edge before and on the edge where each change is due, so an off-by-one in any counter shows up. A bench-side model, built around a remaining-cycles count, is compared with all outputs on every falling edge during directed and random traffic.

// File: rtl/ddr_refresh_sched.sv
`timescale 1ns/1ps
module ddr_refresh_sched #(
  parameter int CLK_PS        = 3000,
  parameter int REFI_NORM_NS  = 7800,
  parameter int REFI_HOT_NS   = 3900,
  parameter int RFC_NS        = 105,
  parameter int XSNR_EXTRA_NS = 10,
  parameter int XSRD_CK       = 200,
  parameter int MAX_PEND      = 8,
  localparam int PEND_W       = $clog2(MAX_PEND + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hot_i,
  input  logic              ref_done_i,
  input  logic              sr_enter_i,
  input  logic              sr_exit_i,
  output logic              ref_req_o,
  output logic              busy_o,
  output logic              rdy_nonread_o,
  output logic              rdy_read_o,
  output logic [PEND_W-1:0] pend_o,
  output logic              overflow_o
);
  localparam int NORM_CK = (REFI_NORM_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int HOT_CK  = (REFI_HOT_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int RFC_CK  = (RFC_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int XSNR_CK = ((RFC_NS + XSNR_EXTRA_NS) * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int IW      = $clog2(NORM_CK > HOT_CK ? NORM_CK : HOT_CK);
  localparam int RW      = $clog2(RFC_CK + 1);
  localparam int XW      = $clog2(XSRD_CK + 1);

  logic [IW-1:0] ivl_cnt;
  logic [RW-1:0] rfc_cnt;
  logic [XW-1:0] xs_cnt;
  logic          in_sr;

  wire due      = !in_sr && (ivl_cnt == '0);
  wire exit_ok  = in_sr && sr_exit_i;
  wire enter_ok = !in_sr && sr_enter_i;
  wire take     = ref_req_o && ref_done_i;
  wire [IW-1:0] reload = hot_i ? IW'(HOT_CK - 1) : IW'(NORM_CK - 1);

  assign ref_req_o     = (pend_o != '0) && (rfc_cnt == '0) && !in_sr;
  assign busy_o        = (rfc_cnt != '0);
  assign rdy_nonread_o = !in_sr && (xs_cnt >= XW'(XSNR_CK));
  assign rdy_read_o    = !in_sr && (xs_cnt == XW'(XSRD_CK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ivl_cnt <= IW'(NORM_CK - 1);
    else if (exit_ok || due) ivl_cnt <= reload;
    else if (!in_sr)         ivl_cnt <= ivl_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o     <= '0;
      overflow_o <= 1'b0;
    end else if (due && !take) begin
      if (pend_o == PEND_W'(MAX_PEND)) overflow_o <= 1'b1;
      else                             pend_o     <= pend_o + 1'b1;
    end else if (take && !due) begin
      pend_o <= pend_o - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rfc_cnt <= '0;
    else if (take)    rfc_cnt <= RW'(RFC_CK);
    else if (busy_o)  rfc_cnt <= rfc_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        in_sr <= 1'b0;
    else if (enter_ok) in_sr <= 1'b1;
    else if (exit_ok)  in_sr <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   xs_cnt <= XW'(XSRD_CK);
    else if (exit_ok)                             xs_cnt <= '0;
    else if (!in_sr && xs_cnt != XW'(XSRD_CK))    xs_cnt <= xs_cnt + 1'b1;
  end
endmodule

// File: rtl/ddr_refresh_sched_chk.sv
`timescale 1ns/1ps
module ddr_refresh_sched_chk #(
  parameter int MAX_PEND = 8,
  parameter int PEND_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_done_i,
  input logic              ref_req_o,
  input logic              busy_o,
  input logic              rdy_nonread_o,
  input logic              rdy_read_o,
  input logic [PEND_W-1:0] pend_o,
  input logic              overflow_o,
  input logic              in_sr
);
  p_take_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req_o && ref_done_i) |=> busy_o);
  p_busy_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(ref_done_i));
  p_busy_no_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !ref_req_o);
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);
  p_pend_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pend_o) <= MAX_PEND);
  p_pend_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pend_o) |-> (int'(pend_o) == int'($past(pend_o)) + 1 ||
                          int'(pend_o) + 1 == int'($past(pend_o))));
  p_sr_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sr && $past(in_sr)) |-> $stable(pend_o));
  p_sr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_sr |-> (!ref_req_o && !rdy_nonread_o && !rdy_read_o));
  p_read_after_nonread_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_read_o |-> rdy_nonread_o);
endmodule

bind ddr_refresh_sched ddr_refresh_sched_chk #(.MAX_PEND(MAX_PEND), .PEND_W(PEND_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_done_i(ref_done_i), .ref_req_o(ref_req_o),
  .busy_o(busy_o), .rdy_nonread_o(rdy_nonread_o), .rdy_read_o(rdy_read_o),
  .pend_o(pend_o), .overflow_o(overflow_o), .in_sr(in_sr)
);

// File: tb/ddr_refresh_sched_bench.sv
`timescale 1ns/1ps
module ddr_refresh_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_PS = 3000;
  localparam int NORM_NS = 780, HOT_NS = 390, RFC_NS = 105, EXTRA_NS = 10, XSRD = 200;
  localparam int MAXP = 8;
  localparam int E_NORM = (NORM_NS * 1000 + CLK_PS - 1) / CLK_PS;               // 260
  localparam int E_HOT  = (HOT_NS * 1000 + CLK_PS - 1) / CLK_PS;                // 130
  localparam int E_RFC  = (RFC_NS * 1000 + CLK_PS - 1) / CLK_PS;                // 35
  localparam int E_XSNR = ((RFC_NS + EXTRA_NS) * 1000 + CLK_PS - 1) / CLK_PS;   // 39

  logic clk = 0, rst_n = 0, hot_i = 0, ref_done_i = 0, sr_enter_i = 0, sr_exit_i = 0;
  logic ref_req_o, busy_o, rdy_nonread_o, rdy_read_o, overflow_o;
  logic [3:0] pend_o;
  int checks = 0, fails = 0, cyc = 0;

  ddr_refresh_sched #(.CLK_PS(CLK_PS), .REFI_NORM_NS(NORM_NS), .REFI_HOT_NS(HOT_NS),
    .RFC_NS(RFC_NS), .XSNR_EXTRA_NS(EXTRA_NS), .XSRD_CK(XSRD), .MAX_PEND(MAXP)) u_ddr_refresh_sched (
    .clk(clk), .rst_n(rst_n), .hot_i(hot_i), .ref_done_i(ref_done_i),
    .sr_enter_i(sr_enter_i), .sr_exit_i(sr_exit_i), .ref_req_o(ref_req_o),
    .busy_o(busy_o), .rdy_nonread_o(rdy_nonread_o), .rdy_read_o(rdy_read_o),
    .pend_o(pend_o), .overflow_o(overflow_o));

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", tag, cyc, got, exp);
    end
  endtask

  // Bench model: remaining cycles to the next due refresh
  int m_left, m_pend, m_busy, m_xs;
  bit m_ovf, m_sr;
  always @(posedge clk) begin
    bit req_now, acc, due;
    if (!rst_n) begin
      m_left = E_NORM; m_pend = 0; m_busy = 0; m_xs = XSRD; m_ovf = 0; m_sr = 0;
    end else begin
      req_now = (m_pend > 0) && (m_busy == 0) && !m_sr;
      acc = req_now && ref_done_i;
      due = 0;
      if (m_sr) begin
        if (sr_exit_i) begin m_sr = 0; m_left = hot_i ? E_HOT : E_NORM; m_xs = 0; end
      end else begin
        if (m_xs < XSRD) m_xs++;
        if (m_left == 1) begin due = 1; m_left = hot_i ? E_HOT : E_NORM; end
        else m_left--;
        if (sr_enter_i) m_sr = 1;
      end
      if (due && !acc) begin
        if (m_pend == MAXP) m_ovf = 1; else m_pend++;
      end else if (acc && !due) m_pend--;
      if (acc) m_busy = E_RFC; else if (m_busy > 0) m_busy--;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk("R4 ref_req_o vs model", ref_req_o, (m_pend > 0) && (m_busy == 0) && !m_sr);
    chk("R5 busy_o vs model", busy_o, m_busy > 0);
    chk("R2 pend_o vs model", pend_o, m_pend);
    chk("R6 overflow_o vs model", overflow_o, m_ovf);
    chk("R8 rdy_nonread_o vs model", rdy_nonread_o, !m_sr && m_xs >= E_XSNR);
    chk("R9 rdy_read_o vs model", rdy_read_o, !m_sr && m_xs >= XSRD);
  end

  task automatic wait_cyc(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  initial begin
    int unsigned sd;
    int x;
    sd = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk("R1 reset req", ref_req_o, 0); chk("R1 reset busy", busy_o, 0);
    chk("R1 reset pend", pend_o, 0); chk("R1 reset ovf", overflow_o, 0);
    chk("R1 reset rdy_nonread", rdy_nonread_o, 1); chk("R1 reset rdy_read", rdy_read_o, 1);
    rst_n = 1;
    wait_cyc(E_NORM - 1); chk("R2 no refresh before interval", pend_o, 0);
    wait_cyc(E_NORM);     chk("R2 refresh due at interval", pend_o, 1);
    chk("R4 request raised", ref_req_o, 1);
    @(negedge clk); pulse(ref_done_i);
    chk("R5 busy after accept", busy_o, 1); chk("R4 pend after accept", pend_o, 0);
    repeat (E_RFC - 1) @(negedge clk); chk("R5 busy last cycle", busy_o, 1);
    @(negedge clk); chk("R5 busy ends", busy_o, 0);
    pulse(ref_done_i);
    chk("R4 done ignored with no request: busy", busy_o, 0);
    chk("R4 done ignored with no request: pend", pend_o, 0);
    hot_i = 1;
    wait_cyc(2 * E_NORM - 1); chk("R3 old interval still running", pend_o, 0);
    wait_cyc(2 * E_NORM);     chk("R3 old interval completes", pend_o, 1);
    wait_cyc(2 * E_NORM + E_HOT - 1); chk("R3 hot interval not yet", pend_o, 1);
    wait_cyc(2 * E_NORM + E_HOT);     chk("R3 hot interval due", pend_o, 2);
    wait_cyc(2 * E_NORM + (MAXP - 1) * E_HOT); chk("R6 pend reaches max", pend_o, MAXP);
    wait_cyc(2 * E_NORM + MAXP * E_HOT - 1);   chk("R6 no overflow yet", overflow_o, 0);
    wait_cyc(2 * E_NORM + MAXP * E_HOT);
    chk("R6 overflow set", overflow_o, 1); chk("R6 pend saturated", pend_o, MAXP);
    ref_done_i = 1; @(negedge clk);
    chk("R4 accepted at saturation", pend_o, MAXP - 1);
    @(negedge clk); ref_done_i = 0;
    chk("R4 done ignored while busy", pend_o, MAXP - 1);
    pulse(sr_enter_i);
    chk("R7 request low in self-refresh", ref_req_o, 0);
    chk("R7 nonread ready low", rdy_nonread_o, 0); chk("R7 read ready low", rdy_read_o, 0);
    repeat (200) @(negedge clk);
    pulse(ref_done_i);
    repeat (300) @(negedge clk);
    chk("R7 pend frozen", pend_o, MAXP - 1); chk("R6 overflow sticky", overflow_o, 1);
    pulse(sr_exit_i);
    x = cyc;
    chk("R8 nonread not ready at exit", rdy_nonread_o, 0);
    chk("R4 request resumes after exit", ref_req_o, 1);
    wait_cyc(x + E_XSNR - 1); chk("R8 nonread ready one early", rdy_nonread_o, 0);
    wait_cyc(x + E_XSNR);     chk("R8 nonread ready", rdy_nonread_o, 1);
    chk("R9 read not yet", rdy_read_o, 0);
    wait_cyc(x + E_HOT - 1);  chk("R8 full interval after exit", pend_o, MAXP - 1);
    wait_cyc(x + E_HOT);      chk("R8 due one interval after exit", pend_o, MAXP);
    wait_cyc(x + XSRD - 1);   chk("R9 read ready one early", rdy_read_o, 0);
    wait_cyc(x + XSRD);       chk("R9 read ready", rdy_read_o, 1);
    pulse(sr_exit_i);
    chk("R8 exit outside self-refresh ignored", rdy_read_o, 1);

    rst_n = 0; hot_i = 0; repeat (2) @(negedge clk); rst_n = 1;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(299) == 0) hot_i = ~hot_i;
      ref_done_i = ($urandom_range(5) == 0);
      sr_enter_i = ($urandom_range(799) == 0);
      sr_exit_i  = ($urandom_range(99) == 0);
      @(negedge clk);
    end
    ref_done_i = 0; sr_enter_i = 0; sr_exit_i = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired at cycle %0d: got 0 expected 1 (completion)", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule